// File: doc/BRIEF.md
# Address-Range Qualified Event Counter

This block counts performance events, but only those whose address falls inside a programmed range. Each clock it may receive an event strobe together with a 64-bit address and a flag that tells whether the address belongs to an instruction fetch or to a data access. Software programs the ranges through a simple write port. The block keeps a 64-bit count of every qualifying event and can clear it synchronously.

There are two ways to describe a range. The exact window is a half-open interval between a lower and an upper bound, and it is only accepted when both bounds lie on the same 4 KB page. Four coarse regions each describe an aligned power-of-two block as a match value plus a mask, and any enabled region may qualify an event. Data addresses always go through the coarse regions. Instruction addresses use the exact window when it is accepted and fall back to the coarse regions when it is not. A status output reports whether the exact window is currently accepted.

Top module: `range_event_counter`

## Requirements
- R1: After reset the count is 0, `fine_ok` is 0, the exact window is disabled and all four coarse regions are disabled.
- R2: `fine_ok` is 1 exactly when the exact-window enable (control bit 0) is set and the lower and upper bounds agree in bits [63:12]. It reflects a write on the clock after that write.
- R3: While `fine_ok` is 1, an instruction event (`ev_is_data` = 0) counts if and only if lower <= address < upper. The coarse regions have no effect on instruction events in this state.
- R4: A data event (`ev_is_data` = 1) never uses the exact window. It counts only if an enabled coarse region matches, whatever the state of `fine_ok`.
- R5: Coarse region k matches when (address XOR match_k) AND mask_k is zero and its enable (control bit k+1) is set. An event that matches several enabled regions is counted once.
- R6: While `fine_ok` is 0, instruction events are qualified by the coarse regions.
- R7: Each qualifying strobe raises the count by exactly one on the rising edge that samples it. A cycle with no qualifying strobe leaves the count unchanged.
- R8: `clr` sets the count to 0 on the next rising edge and overrides a qualifying strobe in the same cycle.
- R9: With no region enabled and the exact window not accepted, no event is counted.
- R10: Write select codes: 0 lower bound, 1 upper bound, 2 control (bit 0 exact-window enable, bits 4:1 region enables), 4+2k match of region k, 5+2k mask of region k. Codes 3 and 12 to 15 change nothing. A write affects events from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the count |
| ev_valid | input | 1 | Event strobe |
| ev_addr | input | 64 | Address carried by the event |
| ev_is_data | input | 1 | 1: data address, 0: instruction address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| count | output | 64 | Number of qualifying events |
| fine_ok | output | 1 | Exact window enabled and legal |

## Verification
Both results are due one rising edge after their cause: the count moves on the edge that samples a qualifying strobe or a clear, and `fine_ok` moves on the edge that stores a bound or control write. The bench drives inputs on the falling edge, updates its behavioural model on the same rising edge as the design, and compares both outputs 1 ns after every rising edge. Directed checks on count deltas are taken after one further idle cycle, so the last strobe of a group has already been registered.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int ADDR_W = 64;
  typedef logic [ADDR_W-1:0] addr_t;

  // Both bounds share every bit above the page offset.
  function automatic logic page_shared(addr_t a, addr_t b, int unsigned pbits);
    return ((a ^ b) >> pbits) == '0;
  endfunction

  // Half-open window lo <= a < hi.
  function automatic logic window_hit(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a < hi);
  endfunction

  // Aligned region: masked bits of address equal masked bits of match.
  function automatic logic region_hit(addr_t a, addr_t m, addr_t k);
    return ((a ^ m) & k) == '0;
  endfunction
endpackage

// File: rtl/rec_cfg_regs.sv
module rec_cfg_regs
  import rec_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int SEL_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  addr_t                 cfg_wdata,
  output addr_t                 fine_lo,
  output addr_t                 fine_hi,
  output logic                  fine_en,
  output logic [NUM_PAIRS-1:0]  pair_en,
  output addr_t [NUM_PAIRS-1:0] pair_match,
  output addr_t [NUM_PAIRS-1:0] pair_mask
);
  localparam logic [SEL_W-1:0] SEL_LO  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_HI  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_CTL = SEL_W'(2);
  localparam int               PAIR_BASE = 4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_lo <= '0;
      fine_hi <= '0;
      fine_en <= 1'b0;
      pair_en <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_LO)  fine_lo <= cfg_wdata;
      if (cfg_sel == SEL_HI)  fine_hi <= cfg_wdata;
      if (cfg_sel == SEL_CTL) begin
        fine_en <= cfg_wdata[0];
        pair_en <= cfg_wdata[NUM_PAIRS:1];
      end
    end
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    localparam logic [SEL_W-1:0] SEL_M = SEL_W'(PAIR_BASE + 2*k);
    localparam logic [SEL_W-1:0] SEL_K = SEL_W'(PAIR_BASE + 2*k + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pair_match[k] <= '0;
        pair_mask[k]  <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == SEL_M) pair_match[k] <= cfg_wdata;
        if (cfg_sel == SEL_K) pair_mask[k]  <= cfg_wdata;
      end
    end
  end
endmodule

// File: rtl/rec_fine_window.sv
module rec_fine_window
  import rec_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  addr_t addr,
  input  addr_t lo,
  input  addr_t hi,
  input  logic  en,
  output logic  accepted,
  output logic  hit
);
  always_comb begin
    accepted = en && page_shared(lo, hi, PAGE_BITS);
    hit      = window_hit(addr, lo, hi);
  end
endmodule

// File: rtl/rec_coarse_bank.sv
module rec_coarse_bank
  import rec_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  addr_t                 addr,
  input  logic [NUM_PAIRS-1:0]  pair_en,
  input  addr_t [NUM_PAIRS-1:0] pair_match,
  input  addr_t [NUM_PAIRS-1:0] pair_mask,
  output logic                  any_hit
);
  logic [NUM_PAIRS-1:0] hits;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_cmp
    assign hits[k] = pair_en[k] && region_hit(addr, pair_match[k], pair_mask[k]);
  end

  assign any_hit = |hits;
endmodule

// File: rtl/rec_event_count.sv
module rec_event_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (inc)  count <= count + ONE;
  end
endmodule

// File: rtl/range_event_counter.sv
module range_event_counter
  import rec_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int NUM_PAIRS = 4,
  parameter int PAGE_BITS = 12,
  parameter int SEL_W     = $clog2(4 + 2*NUM_PAIRS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_is_data,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  count,
  output logic              fine_ok
);
  addr_t                 fine_lo, fine_hi;
  logic                  fine_en;
  logic [NUM_PAIRS-1:0]  pair_en;
  addr_t [NUM_PAIRS-1:0] pair_match, pair_mask;

  // Named internal events for the checker.
  logic fine_hit_w;
  logic coarse_hit_w;
  logic use_fine_w;
  logic qual_w;

  rec_cfg_regs #(.NUM_PAIRS(NUM_PAIRS), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fine_lo(fine_lo), .fine_hi(fine_hi),
    .fine_en(fine_en), .pair_en(pair_en), .pair_match(pair_match),
    .pair_mask(pair_mask)
  );

  rec_fine_window #(.PAGE_BITS(PAGE_BITS)) u_fine (
    .addr(ev_addr), .lo(fine_lo), .hi(fine_hi), .en(fine_en),
    .accepted(fine_ok), .hit(fine_hit_w)
  );

  rec_coarse_bank #(.NUM_PAIRS(NUM_PAIRS)) u_coarse (
    .addr(ev_addr), .pair_en(pair_en), .pair_match(pair_match),
    .pair_mask(pair_mask), .any_hit(coarse_hit_w)
  );

  // Instruction events take the exact window when it is legal;
  // data events and rejected windows use the coarse regions.
  assign use_fine_w = fine_ok && !ev_is_data;
  assign qual_w     = ev_valid && (use_fine_w ? fine_hit_w : coarse_hit_w);

  rec_event_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(qual_w), .count(count)
  );
endmodule

// File: rtl/rec_chk.sv
module rec_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             ev_valid,
  input logic             ev_is_data,
  input logic [CNT_W-1:0] count,
  input logic             fine_ok,
  input logic             fine_hit_w,
  input logic             coarse_hit_w,
  input logic             qual_w
);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  a_r7_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && qual_w) |=> (count == $past(count) + CNT_W'(1)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !qual_w) |=> $stable(count));

  a_r4_data_coarse_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_is_data) |-> (qual_w == coarse_hit_w));

  a_r3_fine_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_is_data && fine_ok) |-> (qual_w == fine_hit_w));

  a_r6_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_is_data && !fine_ok) |-> (qual_w == coarse_hit_w));

  a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> !qual_w);
endmodule

bind range_event_counter rec_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ev_valid(ev_valid),
  .ev_is_data(ev_is_data), .count(count), .fine_ok(fine_ok),
  .fine_hit_w(fine_hit_w), .coarse_hit_w(coarse_hit_w), .qual_w(qual_w)
);

// File: tb/range_event_counter_tb.sv
`timescale 1ns/1ps
module range_event_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        ev_valid = 1'b0;
  logic [63:0] ev_addr = '0;
  logic        ev_is_data = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] count;
  logic        fine_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  range_event_counter u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_valid(ev_valid),
    .ev_addr(ev_addr), .ev_is_data(ev_is_data), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .count(count), .fine_ok(fine_ok)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_lo, m_hi, exp_count;
  logic        m_fen;
  logic [3:0]  m_pen;
  logic [63:0] m_match [4];
  logic [63:0] m_mask  [4];

  function automatic logic model_fine_ok();
    return m_fen && ((m_lo ^ m_hi) < 64'h1000);
  endfunction

  function automatic logic model_qual(logic [63:0] a, logic d);
    logic q;
    q = 1'b0;
    if (!d && model_fine_ok()) begin
      q = (a >= m_lo) && (a < m_hi);
    end else begin
      for (int k = 0; k < 4; k++)
        if (m_pen[k] && (((a ^ m_match[k]) & m_mask[k]) == 64'h0)) q = 1'b1;
    end
    return q;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= '0; m_hi <= '0; m_fen <= 1'b0; m_pen <= '0; exp_count <= '0;
      for (int k = 0; k < 4; k++) begin m_match[k] <= '0; m_mask[k] <= '0; end
    end else begin
      if (clr) exp_count <= '0;
      else if (ev_valid && model_qual(ev_addr, ev_is_data)) exp_count <= exp_count + 1;
      if (cfg_we) begin
        if (cfg_sel == 4'd0) m_lo <= cfg_wdata;
        else if (cfg_sel == 4'd1) m_hi <= cfg_wdata;
        else if (cfg_sel == 4'd2) begin m_fen <= cfg_wdata[0]; m_pen <= cfg_wdata[4:1]; end
        else if (cfg_sel >= 4'd4 && cfg_sel < 4'd12) begin
          if (cfg_sel[0]) m_mask[(int'(cfg_sel) - 4) / 2] <= cfg_wdata;
          else            m_match[(int'(cfg_sel) - 4) / 2] <= cfg_wdata;
        end
      end
    end
  end

  // Compare every clock, 1 ns after the rising edge.
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      checks++;
      if (count !== exp_count) begin
        errors++;
        $display("FAIL %s cycle count: actual=%0d expected=%0d", cur_req, count, exp_count);
      end
      checks++;
      if (fine_ok !== model_fine_ok()) begin
        errors++;
        $display("FAIL R2 cycle fine_ok: actual=%0b expected=%0b", fine_ok, model_fine_ok());
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(logic v, logic [63:0] a, logic d, logic c,
                      logic we, logic [3:0] s, logic [63:0] w);
    @(negedge clk);
    ev_valid = v; ev_addr = a; ev_is_data = d; clr = c;
    cfg_we = we; cfg_sel = s; cfg_wdata = w;
  endtask

  task automatic wr(logic [3:0] s, logic [63:0] w);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, s, w);
  endtask

  task automatic ev(logic [63:0] a, logic d);
    step(1'b1, a, d, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic chk(logic [63:0] act, logic [63:0] exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pick_addr();
    logic [63:0] b;
    case ($urandom % 3)
      0: b = 64'h1000_0000;
      1: b = 64'h2000_0000;
      default: b = 64'h1000_1000;
    endcase
    return b + 64'($urandom % 32'h400);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [63:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    cur_req = "R1";
    chk(count, 64'd0, "R1", "count after reset");
    chk({63'd0, fine_ok}, 64'd0, "R1", "fine_ok after reset");

    // R9: nothing enabled
    cur_req = "R9";
    ev(64'h1000_0000, 1'b0); ev(64'h0, 1'b1); ev(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    idle();
    chk(count, 64'd0, "R9", "no region enabled");

    // R2/R3: exact window on one page
    cur_req = "R3";
    wr(4'd0, 64'h1000_0100); wr(4'd1, 64'h1000_0180); wr(4'd2, 64'h1);
    idle();
    chk({63'd0, fine_ok}, 64'd1, "R2", "window on one page accepted");
    base = count;
    ev(64'h1000_0100, 1'b0); ev(64'h1000_017F, 1'b0);
    ev(64'h1000_0180, 1'b0); ev(64'h1000_00FF, 1'b0);
    ev(64'h1000_0140, 1'b1);
    idle();
    chk(count - base, 64'd2, "R3", "half-open window");

    // R4: data only via coarse, coarse ignored for instr while window legal
    cur_req = "R4";
    wr(4'd4, 64'h1000_0000); wr(4'd5, ~64'hFFF); wr(4'd2, 64'h3);
    idle();
    base = count;
    ev(64'h1000_0200, 1'b0);
    ev(64'h1000_0140, 1'b1); ev(64'h1000_0FFF, 1'b1); ev(64'h1000_1000, 1'b1);
    idle();
    chk(count - base, 64'd2, "R4", "data events via coarse region");

    // R2/R6: window across pages rejected, fallback to coarse
    cur_req = "R6";
    wr(4'd1, 64'h1000_2000);
    idle();
    chk({63'd0, fine_ok}, 64'd0, "R2", "window across pages rejected");
    base = count;
    ev(64'h1000_0200, 1'b0); ev(64'h1000_1800, 1'b0); ev(64'h1000_0100, 1'b0);
    idle();
    chk(count - base, 64'd2, "R6", "instruction fallback to coarse");

    // R5: overlapping regions counted once, disable one region
    cur_req = "R5";
    wr(4'd6, 64'h2000_0000); wr(4'd7, ~64'hFF);
    wr(4'd8, 64'h2000_0000); wr(4'd9, ~64'hFFFF);
    wr(4'd2, 64'hF);
    idle();
    base = count;
    ev(64'h2000_0010, 1'b1); ev(64'h2000_0F00, 1'b1);
    wr(4'd2, 64'h7);
    ev(64'h2000_0F00, 1'b1); ev(64'h2000_00FF, 1'b0);
    idle();
    chk(count - base, 64'd3, "R5", "OR of regions, counted once");

    // R10: unused selects change nothing
    cur_req = "R10";
    wr(4'd3, 64'h0); wr(4'd12, 64'h0); wr(4'd15, 64'h0); wr(4'd13, 64'h0);
    idle();
    base = count;
    ev(64'h2000_0010, 1'b1); ev(64'h1000_0140, 1'b1);
    idle();
    chk(count - base, 64'd2, "R10", "unused selects ignored");

    // R7: back-to-back strobes
    cur_req = "R7";
    base = count;
    for (int i = 0; i < 10; i++) ev(64'h1000_0300, 1'b1);
    idle();
    chk(count - base, 64'd10, "R7", "ten consecutive strobes");

    // R8: clear beats a qualifying strobe
    cur_req = "R8";
    step(1'b1, 64'h1000_0300, 1'b1, 1'b1, 1'b0, '0, '0);
    idle();
    chk(count, 64'd0, "R8", "clear with simultaneous strobe");
    ev(64'h1000_0300, 1'b1);
    idle();
    chk(count, 64'd1, "R7", "single strobe after clear");

    // R9: everything disabled again
    cur_req = "R9";
    wr(4'd2, 64'h0);
    idle();
    base = count;
    ev(64'h1000_0300, 1'b1); ev(64'h2000_0010, 1'b0); ev(64'h1000_0100, 1'b0);
    idle();
    chk(count - base, 64'd0, "R9", "all disabled");

    // Mixed random traffic checked by the model every cycle
    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      int r;
      int unsigned s;
      logic [63:0] w;
      r = int'($urandom % 12);
      if (r < 7) ev(pick_addr(), 1'($urandom % 2));
      else if (r < 10) begin
        s = $urandom % 16;
        if (s == 2) w = 64'($urandom % 32);
        else if (s >= 5 && s[0]) w = ~((64'h1 << ($urandom % 14)) - 64'h1);
        else w = pick_addr();
        wr(4'(s), w);
      end else if (r == 10) step(1'b1, pick_addr(), 1'b0, 1'b1, 1'b0, '0, '0);
      else idle();
    end
    idle();
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule